// File: doc/BRIEF.md
# Read Completion Splitter

This block sits behind the request decoder of a memory-read completer. It accepts one read request at a time: a start byte address, a length in dwords, the requester ID and the tag. It then issues the header fields of every completion that answers the request, one descriptor per clock, over a valid/ready handshake. For each descriptor it works out how many payload bytes the completion carries, the byte-count field and the lower-address field. The data path that fetches the payload and the logic that serialises the packets use these descriptors. Neither of them is part of this block.

The size of each completion is set by three limits, applied in this order. The first is the maximum payload size, taken from a 3-bit code. The second is a trim that makes any completion longer than one 128-byte read completion boundary end on such a boundary. The third keeps every completion inside one 4 KB page. The address and the issued-byte total both advance by each chunk until the whole request has been covered.

Top module: `rdcpl_splitter`

## Requirements
- R1: During and after reset, busy and cpl_valid are low and req_ready is high until a request is accepted.
- R2: An accepted request is covered by a run of descriptors. Their cpl_len_bytes values add up to exactly dw_len×4 bytes, cpl_last is high only on the final descriptor, and busy drops after that descriptor's handshake.
- R3: Every descriptor's cpl_byte_cnt equals the bytes of the request not yet issued, counted before that descriptor's own payload is subtracted.
- R4: No cpl_len_bytes exceeds 128 << code, where code is the 3-bit mps_code sampled when the request was accepted. Later changes of mps_code do not affect a request in progress. Every cpl_len_bytes is non-zero.
- R5: If the candidate length min(remaining, max payload) is above 128 bytes, it is reduced by (current address + candidate) mod 128, so that the completion ends on a 128-byte boundary.
- R6: After R5, the length is capped at 4096 − (current address mod 4096), so no completion crosses a 4 KB page.
- R7: cpl_lower_addr is bits [6:0] of the current byte address. The current address starts at req_addr and grows by each issued cpl_len_bytes.
- R8: Every descriptor carries the accepted request's requester ID and tag, and cpl_status is 3'b000 (successful completion).
- R9: req_ready is low while busy. Request fields presented during that time are ignored and do not change the descriptor run in progress.
- R10: A req_dw_len of 0 means 1024 dwords (4096 bytes).
- R11: While cpl_valid is high and cpl_ready is low, the descriptor fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_dw_len | input | LEN_W | Length in dwords, 0 = 1024 |
| req_rid | input | RID_W | Requester ID |
| req_tag | input | TAG_W | Request tag |
| mps_code | input | MPS_W | Max payload code, bytes = 128 << code |
| cpl_valid | output | 1 | Descriptor valid |
| cpl_ready | input | 1 | Descriptor consumed |
| cpl_len_bytes | output | LEN_W+3 | Payload bytes of this completion |
| cpl_byte_cnt | output | LEN_W+3 | Bytes still remaining, including this completion |
| cpl_lower_addr | output | log2(RCB_BYTES) | Low address bits of this completion |
| cpl_rid | output | RID_W | Echoed requester ID |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_status | output | 3 | Completion status, 000 = success |
| cpl_last | output | 1 | Final descriptor of the request |
| busy | output | 1 | A request is being split |

## Verification
The bench targets the points where the three limits interact. These are a request that starts a few bytes before a page end, a chunk whose 128-byte trim and page cap both apply, a zero length that must produce 4096 bytes, and the largest payload code, where only the trim and the page cap limit the chunk. An incorrect trim would leave completions ending off a 128-byte boundary or one byte short. An incorrect page cap would let a completion cross into the next page. Reading length 0 literally would end the run at once with no bytes. Back-pressure and noise inputs during a run (new request fields and a changing payload code) catch a design that drops fields while stalled or re-samples inputs it should hold.

// File: rtl/rdcpl_pkg.sv
package rdcpl_pkg;
   typedef enum logic [2:0] {
      CPL_SC = 3'b000,
      CPL_UR = 3'b001,
      CPL_CA = 3'b100
   } cpl_status_e;
endpackage

// File: rtl/rdcpl_chunk_calc.sv
module rdcpl_chunk_calc #(
   parameter int BC_W       = 13,
   parameter int MPS_W      = 3,
   parameter int RCB_BYTES  = 128,
   parameter int PAGE_BYTES = 4096
) (
   input  logic [$clog2(PAGE_BYTES)-1:0] page_off,
   input  logic [BC_W-1:0]               remaining,
   input  logic [MPS_W-1:0]              mps_code,
   output logic [BC_W-1:0]               chunk
);
   localparam int RCB_W   = $clog2(RCB_BYTES);
   localparam int MAXPL_W = RCB_W + (1 << MPS_W);
   localparam int CW      = ((MAXPL_W > BC_W) ? MAXPL_W : BC_W) + 1;

   logic [CW-1:0] maxpl, cand, trim, trimmed, room, sized;

   // max payload -> rcb trim -> page cap, in that order
   always_comb begin
      maxpl   = CW'(RCB_BYTES) << mps_code;
      cand    = (CW'(remaining) < maxpl) ? CW'(remaining) : maxpl;
      trim    = CW'(CW'(page_off) + cand) & CW'(RCB_BYTES - 1);
      trimmed = (cand > CW'(RCB_BYTES)) ? (cand - trim) : cand;
      room    = CW'(PAGE_BYTES) - CW'(page_off);
      sized   = (trimmed > room) ? room : trimmed;
      chunk   = BC_W'(sized);
   end
endmodule

// File: rtl/rdcpl_tracker.sv
module rdcpl_tracker #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 10,
   parameter int RID_W  = 16,
   parameter int TAG_W  = 8,
   parameter int MPS_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              advance,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_dw_len,
   input  logic [RID_W-1:0]  req_rid,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [MPS_W-1:0]  req_mps,
   input  logic [LEN_W+2:0]  chunk,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LEN_W+2:0]  remaining,
   output logic [RID_W-1:0]  rid_q,
   output logic [TAG_W-1:0]  tag_q,
   output logic [MPS_W-1:0]  mps_q,
   output logic              busy,
   output logic              last
);
   localparam int BC_W = LEN_W + 3;
   localparam logic [BC_W-1:0] FULL_BYTES = BC_W'(1) << (LEN_W + 2);

   logic [BC_W-1:0] req_bytes;

   always_comb begin
      req_bytes = (req_dw_len == '0) ? FULL_BYTES : {1'b0, req_dw_len, 2'b00};
      last      = (remaining == chunk);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy      <= 1'b0;
         cur_addr  <= '0;
         remaining <= '0;
         rid_q     <= '0;
         tag_q     <= '0;
         mps_q     <= '0;
      end else if (start) begin
         busy      <= 1'b1;
         cur_addr  <= req_addr;
         remaining <= req_bytes;
         rid_q     <= req_rid;
         tag_q     <= req_tag;
         mps_q     <= req_mps;
      end else if (advance) begin
         cur_addr  <= cur_addr + ADDR_W'(chunk);
         remaining <= remaining - chunk;
         if (last) busy <= 1'b0;
      end
   end

   // R9: a new request only lands on an idle tracker
   p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy);
   // R2: the last handshake ends the run
   p_last_clears_r2: assert property (@(posedge clk) disable iff (rst)
      advance && last |=> !busy);
   // R2: a non-last handshake keeps the run going
   p_not_last_holds_r2: assert property (@(posedge clk) disable iff (rst)
      advance && !last |=> busy);
endmodule

// File: rtl/rdcpl_splitter.sv
module rdcpl_splitter #(
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 10,
   parameter int RID_W      = 16,
   parameter int TAG_W      = 8,
   parameter int MPS_W      = 3,
   parameter int RCB_BYTES  = 128,
   parameter int PAGE_BYTES = 4096
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [LEN_W-1:0]              req_dw_len,
   input  logic [RID_W-1:0]              req_rid,
   input  logic [TAG_W-1:0]              req_tag,
   input  logic [MPS_W-1:0]              mps_code,
   output logic                          cpl_valid,
   input  logic                          cpl_ready,
   output logic [LEN_W+2:0]              cpl_len_bytes,
   output logic [LEN_W+2:0]              cpl_byte_cnt,
   output logic [$clog2(RCB_BYTES)-1:0]  cpl_lower_addr,
   output logic [RID_W-1:0]              cpl_rid,
   output logic [TAG_W-1:0]              cpl_tag,
   output logic [2:0]                    cpl_status,
   output logic                          cpl_last,
   output logic                          busy
);
   import rdcpl_pkg::*;

   localparam int BC_W    = LEN_W + 3;
   localparam int RCB_W   = $clog2(RCB_BYTES);
   localparam int PAGE_W  = $clog2(PAGE_BYTES);
   localparam int MAXPL_W = RCB_W + (1 << MPS_W) + 1;

   // elaboration-time parameter checks
   generate
      if ((1 << RCB_W) != RCB_BYTES) begin : g_bad_rcb
         $error("RCB_BYTES must be a power of two");
      end
      if ((1 << PAGE_W) != PAGE_BYTES || PAGE_BYTES < RCB_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two no smaller than RCB_BYTES");
      end
      if (PAGE_W >= BC_W || ADDR_W <= PAGE_W) begin : g_bad_width
         $error("LEN_W and ADDR_W too small for the page size");
      end
   endgenerate

   logic              start, advance, last;
   logic [ADDR_W-1:0] cur_addr;
   logic [BC_W-1:0]   remaining, chunk;
   logic [RID_W-1:0]  rid_q;
   logic [TAG_W-1:0]  tag_q;
   logic [MPS_W-1:0]  mps_q;

   assign req_ready = !busy;
   assign start     = req_valid && req_ready;
   assign cpl_valid = busy;
   assign advance   = cpl_valid && cpl_ready;

   rdcpl_tracker #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RID_W(RID_W), .TAG_W(TAG_W), .MPS_W(MPS_W)
   ) u_tracker (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .advance   (advance),
      .req_addr  (req_addr),
      .req_dw_len(req_dw_len),
      .req_rid   (req_rid),
      .req_tag   (req_tag),
      .req_mps   (mps_code),
      .chunk     (chunk),
      .cur_addr  (cur_addr),
      .remaining (remaining),
      .rid_q     (rid_q),
      .tag_q     (tag_q),
      .mps_q     (mps_q),
      .busy      (busy),
      .last      (last)
   );

   rdcpl_chunk_calc #(
      .BC_W(BC_W), .MPS_W(MPS_W), .RCB_BYTES(RCB_BYTES), .PAGE_BYTES(PAGE_BYTES)
   ) u_chunk (
      .page_off (cur_addr[PAGE_W-1:0]),
      .remaining(remaining),
      .mps_code (mps_q),
      .chunk    (chunk)
   );

   assign cpl_len_bytes  = chunk;
   assign cpl_byte_cnt   = remaining;
   assign cpl_lower_addr = cur_addr[RCB_W-1:0];
   assign cpl_rid        = rid_q;
   assign cpl_tag        = tag_q;
   assign cpl_status     = CPL_SC;
   assign cpl_last       = last;

   // R1: idle out of reset
   p_reset_idle_r1: assert property (@(posedge clk)
      $past(rst) |-> !busy && !cpl_valid);
   // R3: byte count steps down by the payload just issued
   p_bc_step_r3: assert property (@(posedge clk) disable iff (rst)
      advance && !cpl_last |=> cpl_valid && (cpl_byte_cnt == $past(cpl_byte_cnt) - $past(cpl_len_bytes)));
   // R4: never above the latched max payload, never empty
   p_mps_r4: assert property (@(posedge clk) disable iff (rst)
      cpl_valid |-> (cpl_len_bytes != '0) &&
                    (MAXPL_W'(cpl_len_bytes) <= (MAXPL_W'(RCB_BYTES) << mps_q)));
   // R5: long completions end on an rcb boundary
   p_rcb_end_r5: assert property (@(posedge clk) disable iff (rst)
      cpl_valid && (cpl_len_bytes > BC_W'(RCB_BYTES)) |->
         (RCB_W'(cpl_lower_addr + cpl_len_bytes[RCB_W-1:0]) == '0));
   // R6: no page crossing
   p_page_r6: assert property (@(posedge clk) disable iff (rst)
      cpl_valid |-> ((BC_W + 1)'(cur_addr[PAGE_W-1:0]) + (BC_W + 1)'(cpl_len_bytes)) <= (BC_W + 1)'(PAGE_BYTES));
   // R7: address moves by the issued payload
   p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
      advance && !cpl_last |=> cur_addr == $past(cur_addr) + ADDR_W'($past(cpl_len_bytes)));
   // R11: stalled descriptor holds
   p_stall_stable_r11: assert property (@(posedge clk) disable iff (rst)
      cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_len_bytes) &&
                                  $stable(cpl_byte_cnt) && $stable(cpl_lower_addr));
endmodule

// File: tb/rdcpl_splitter_bench.sv
module rdcpl_splitter_bench;
   localparam int ADDR_W = 64, LEN_W = 10, RID_W = 16, TAG_W = 8, MPS_W = 3;
   localparam int BC_W = LEN_W + 3;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst, req_valid, req_ready, cpl_valid, cpl_ready, cpl_last, busy;
   logic [ADDR_W-1:0] req_addr;
   logic [LEN_W-1:0]  req_dw_len;
   logic [RID_W-1:0]  req_rid, cpl_rid;
   logic [TAG_W-1:0]  req_tag, cpl_tag;
   logic [MPS_W-1:0]  mps_code;
   logic [BC_W-1:0]   cpl_len_bytes, cpl_byte_cnt;
   logic [6:0]        cpl_lower_addr;
   logic [2:0]        cpl_status;

   rdcpl_splitter u_rdcpl_splitter (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_dw_len(req_dw_len), .req_rid(req_rid),
      .req_tag(req_tag), .mps_code(mps_code), .cpl_valid(cpl_valid),
      .cpl_ready(cpl_ready), .cpl_len_bytes(cpl_len_bytes),
      .cpl_byte_cnt(cpl_byte_cnt), .cpl_lower_addr(cpl_lower_addr),
      .cpl_rid(cpl_rid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
      .cpl_last(cpl_last), .busy(busy)
   );

   int total = 0, bad = 0, cyc = 0;
   bit dog = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected chunk from the stated limits: payload cap, rcb trim, page cap
   function automatic int exp_chunk(input logic [63:0] a, input int rem, input int code);
      int c, room;
      c = rem;
      if (c > (128 << code)) c = 128 << code;
      if (c > 128) c = c - ((int'(a[6:0]) + c) % 128);
      room = 4096 - int'(a[11:0]);
      if (c > room) c = room;
      return c;
   endfunction

   task automatic run_req(input logic [63:0] addr, input int len, input int code,
                          input bit stall);
      logic [63:0] m_addr;
      int m_rem, sum, e, want;
      logic [RID_W-1:0] rid;
      logic [TAG_W-1:0] tag;
      bit held;
      logic [BC_W-1:0] h_len, h_bc;
      logic [6:0] h_la;
      if (dog) return;
      rid = RID_W'($urandom);
      tag = TAG_W'($urandom);
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready when idle", req_ready, 1);
      req_valid = 1'b1; req_addr = addr; req_dw_len = LEN_W'(len);
      req_rid = rid; req_tag = tag; mps_code = MPS_W'(code);
      @(negedge clk);
      chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
      m_addr = addr;
      want = (len == 0) ? 4096 : len * 4;
      m_rem = want; sum = 0; held = 0;
      h_len = '0; h_bc = '0; h_la = '0;
      while (m_rem > 0) begin
         if (cyc > LIMIT) begin
            dog = 1;
            chk(0, "R2", "watchdog expired", cyc, LIMIT);
            return;
         end
         if (held) begin
            chk(cpl_len_bytes == h_len && cpl_byte_cnt == h_bc && cpl_lower_addr == h_la,
                "R11", "stalled fields stable", cpl_len_bytes, h_len);
            held = 0;
         end
         chk(cpl_valid == 1'b1, "R2", "valid while bytes remain", cpl_valid, 1);
         chk(req_ready == 1'b0, "R9", "not ready while busy", req_ready, 0);
         // noise on request side: must be ignored
         req_valid = ($urandom % 3 == 0);
         req_addr = {$urandom, $urandom};
         req_dw_len = LEN_W'($urandom);
         req_rid = RID_W'($urandom); req_tag = TAG_W'($urandom);
         mps_code = MPS_W'($urandom);
         cpl_ready = stall ? ($urandom % 4 != 0) : 1'b1;
         if (cpl_ready) begin
            e = exp_chunk(m_addr, m_rem, code);
            chk(int'(cpl_len_bytes) == e, "R4 R5 R6", "chunk length", cpl_len_bytes, e);
            chk(int'(cpl_byte_cnt) == m_rem, "R3", "byte count", cpl_byte_cnt, m_rem);
            chk(cpl_lower_addr == m_addr[6:0], "R7", "lower address", cpl_lower_addr, m_addr[6:0]);
            chk(cpl_rid == rid && cpl_tag == tag && cpl_status == 3'b000, "R8",
                "rid/tag/status", {cpl_rid, cpl_tag}, {rid, tag});
            chk(cpl_last == (m_rem == e), "R2", "last flag", cpl_last, m_rem == e);
            if (e <= 0) e = m_rem;
            m_addr += 64'(e); m_rem -= e; sum += e;
         end else begin
            held = 1; h_len = cpl_len_bytes; h_bc = cpl_byte_cnt; h_la = cpl_lower_addr;
         end
         @(negedge clk);
      end
      req_valid = 1'b0; cpl_ready = 1'b0;
      chk(!busy && !cpl_valid, "R2", "idle after last", busy, 0);
      chk(sum == want, (len == 0) ? "R10" : "R2", "total bytes", sum, want);
   endtask

   initial begin
      void'($urandom(32'd4242));
      rst = 1'b1; req_valid = 1'b0; cpl_ready = 1'b0; req_addr = '0;
      req_dw_len = '0; req_rid = '0; req_tag = '0; mps_code = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !cpl_valid && req_ready, "R1", "state in reset", busy, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(!busy && !cpl_valid && req_ready, "R1", "state after reset", {busy, cpl_valid, req_ready}, 1);
      // directed corners
      run_req(64'h0, 0, 0, 0);                  // R10: 4096 bytes in 128-byte chunks
      run_req(64'h1FFC, 2, 2, 1);               // R6: 4 bytes then 4 bytes over a page edge
      run_req(64'h1010, 128, 1, 1);             // R5: 240, 256, 16
      run_req(64'hFFFF_FFF0_0000_0F40, 64, 5, 0); // R5 and R6 together: 192, 64
      run_req(64'h0000_0000_0000_0A35, 0, 7, 1);  // R4 largest code, R10
      run_req(64'hFFFF_FFFF_FFFF_FF80, 32, 0, 1); // R7 address wraps
      for (int i = 0; i < 300; i++)
         run_req({$urandom, $urandom}, int'($urandom % 1024), int'($urandom % 8), 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule